// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Register

This block guards a processor against running away. Software arms the watchdog by writing a control byte in which the service bit is zero. After that, the same write pattern must recur often enough, or the block raises a one-cycle reset request toward the chip reset generator. The timeout base comes from one of two free-running prescalers. One counts the main clock. The other counts strobes from a slow sub clock, and an input pin chooses between the two. A 2-bit count of rising edges on a chosen prescaler tap decides when the timeout expires. The timeout therefore depends on the prescaler phase at the moment of service, within a window of one tap period.

The same byte-wide register reports why the chip last reset. It has four sticky cause flags: power-on, watchdog expiry, external reset pin, and software request. A power-on reset is the only event that reinitialises the flags. Every other reset leaves them alone, and the event that caused it sets its own flag. A read returns the flags and then clears them. A second register address carries a software reset-request bit.

Top module: `wdog_guard`

## Requirements
- R1: After a power-on reset, a read of address 0 returns 0x87. Bit 7 is the power-on flag and is 1. Bit 6 reads 0. Bits 5, 4 and 3 are the watchdog, external and software flags and are 0. Bits 2:0 always read 1.
- R2: A read of address 0 clears all four cause flags, so an immediate second read returns 0x07. A flag being set in the same cycle as the read stays set.
- R3: Until a write to address 0 with bit 2 = 0, the watchdog stays idle and never raises `wdt_rst_req`. A write with bit 2 = 1 does not arm it.
- R4: Bits 1:0 of the arming write pick tap code k. With the main clock as source, tap code k has period T = 2^MAIN_LOG[k] clock cycles. `wdt_rst_req` rises between 3T and 4T+2 clock cycles after the arming write.
- R5: Every later write to address 0 with bit 2 = 0 restarts the count. Service more often than 3T cycles keeps `wdt_rst_req` low. The next expiry then falls in the R4 window, counted from the last service write.
- R6: The tap code is latched by the arming write. The code bits of later service writes have no effect on the timeout.
- R7: With `src_sel` = 1, the sub-clock prescaler counts `sub_tick` strobes. Tap code k then has period 2^SUB_LOG[k] strobes, and the expiry falls between 3 and 4 such periods after the arming write.
- R8: `wdt_rst_req` is high for exactly one cycle, and the expiry sets the watchdog flag (bit 5).
- R9: A write to address 1 with bit 0 = 1 produces a one-cycle `sw_rst_req` pulse and sets the software flag (bit 3). A write with bit 0 = 0 produces no pulse.
- R10: A low level on `ext_pin_n` sets the external flag (bit 4). Across the resulting system reset, the other flags keep their values.
- R11: A system reset on `rst_n` disarms the watchdog and clears its count but leaves the cause flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| rst_n | input | 1 | System reset, active low, asynchronous |
| ext_pin_n | input | 1 | External reset pin level, active low |
| src_sel | input | 1 | Timeout source: 0 main-clock prescaler, 1 sub-clock prescaler |
| sub_tick | input | 1 | One-cycle strobe per sub-clock period, synchronous to clk |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 1 | 0 control/cause register, 1 software reset register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| wdt_rst_req | output | 1 | One-cycle watchdog reset request |
| sw_rst_req | output | 1 | One-cycle software reset request |

## Verification
The timeout is exercised with one arming write for each of the four main-clock codes. Each expiry is checked against its own window, which shows that every tap is wired to its own prescaler bit. A run on the sub clock, with a sparse strobe, shows that the source select really changes the counted event. A service sequence faster than the window, followed by silence, tells restart apart from arming. Arming with a short code and then servicing with a long one shows whether the code is latched or re-read. Reset sequences of each kind, with reads in between, separate flags that are set, flags that are held and flags that are cleared.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

  // Bit positions in the control/cause register (software decodes these)
  localparam int unsigned POS_POR = 7;
  localparam int unsigned POS_WDT = 5;
  localparam int unsigned POS_EXT = 4;
  localparam int unsigned POS_SW  = 3;
  localparam int unsigned POS_CTL = 2;
  localparam int unsigned NCODES  = 4;

  typedef struct packed {
    logic por;
    logic wdt;
    logic ext;
    logic sw;
  } cause_t;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/wdg_reset_sync.sv
module wdg_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int unsigned WIDTH = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [WIDTH-1:0] count
);
  logic [WIDTH-1:0] count_q;
  logic [WIDTH-1:0] count_d;

  always_comb begin
    count_d = count_q;
    if (adv) count_d = count_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign count = count_q;
endmodule

// File: rtl/wdg_expiry.sv
module wdg_expiry
  import wdg_pkg::*;
#(
  parameter int unsigned MAIN_LOG [NCODES] = '{12, 14, 16, 19},
  parameter int unsigned SUB_LOG  [NCODES] = '{10, 13, 14, 15},
  parameter int unsigned MAIN_W = 19,
  parameter int unsigned SUB_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              kick,
  input  logic [1:0]        code_in,
  input  logic              src_sel,
  input  logic [MAIN_W-1:0] main_cnt,
  input  logic [SUB_W-1:0]  sub_cnt,
  output logic              expire
);
  logic [NCODES-1:0] main_tap, sub_tap;
  logic [NCODES-1:0] main_prev_q, sub_prev_q;
  logic [NCODES-1:0] main_rise, sub_rise;
  logic              sel_rise;
  logic              run_q, run_d;
  logic [1:0]        code_q, code_d;
  logic [1:0]        cnt_q, cnt_d;
  logic              expire_q, expire_d;
  logic              unused_cnt;

  // One tap per code and per source, picked by parameter
  for (genvar g = 0; g < NCODES; g++) begin : g_taps
    assign main_tap[g] = main_cnt[MAIN_LOG[g]-1];
    assign sub_tap[g]  = sub_cnt[SUB_LOG[g]-1];
  end

  assign unused_cnt = ^{main_cnt, sub_cnt};

  // Every tap keeps its own history, so a code or source change gives no false edge
  assign main_rise = main_tap & ~main_prev_q;
  assign sub_rise  = sub_tap  & ~sub_prev_q;

  always_comb begin
    sel_rise = src_sel ? sub_rise[code_q] : main_rise[code_q];
  end

  always_comb begin
    run_d    = run_q | kick;
    code_d   = (kick && !run_q) ? code_in : code_q;
    cnt_d    = cnt_q;
    if (kick)                  cnt_d = 2'd0;
    else if (run_q && sel_rise) cnt_d = cnt_q + 2'd1;
    expire_d = run_q && !kick && sel_rise && (cnt_q == 2'd3);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_prev_q <= '0;
      sub_prev_q  <= '0;
      run_q       <= 1'b0;
      code_q      <= 2'd0;
      cnt_q       <= 2'd0;
      expire_q    <= 1'b0;
    end else begin
      main_prev_q <= main_tap;
      sub_prev_q  <= sub_tap;
      run_q       <= run_d;
      code_q      <= code_d;
      cnt_q       <= cnt_d;
      expire_q    <= expire_d;
    end
  end

  assign expire = expire_q;

  // R8: a request lasts one cycle
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    expire_q |=> !expire_q);
  // R3: an unarmed watchdog never requests
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !expire_q);
  // R5: a service write restarts the count
  a_r5_kick_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt_q == 2'd0));
  // R6: once armed, the code does not move
  a_r6_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |=> $stable(code_q));
endmodule

// File: rtl/wdg_cause_flags.sv
module wdg_cause_flags
  import wdg_pkg::*;
(
  input  logic   clk,
  input  logic   por_rst_n,
  input  logic   set_wdt,
  input  logic   set_sw,
  input  logic   ext_pin_n,
  input  logic   rd_clr,
  output cause_t flags
);
  logic [1:0] ext_sync_q;
  logic       ext_low;
  cause_t     flags_q, flags_d;

  assign ext_low = !ext_sync_q[1];

  always_comb begin
    flags_d = flags_q;
    if (rd_clr) flags_d = '0;
    // a new cause wins over a clearing read in the same cycle
    if (set_wdt) flags_d.wdt = 1'b1;
    if (set_sw)  flags_d.sw  = 1'b1;
    if (ext_low) flags_d.ext = 1'b1;
  end

  always_ff @(posedge clk or negedge por_rst_n) begin
    if (!por_rst_n) begin
      ext_sync_q <= 2'b11;
      flags_q    <= '{por: 1'b1, wdt: 1'b0, ext: 1'b0, sw: 1'b0};
    end else begin
      ext_sync_q <= {ext_sync_q[0], ext_pin_n};
      flags_q    <= flags_d;
    end
  end

  assign flags = flags_q;

  // R2: a read with no competing cause empties the flags
  a_r2_read_clears: assert property (@(posedge clk) disable iff (!por_rst_n)
    (rd_clr && !set_wdt && !set_sw && !ext_low) |=> (flags_q == '0));
  // R9: software request sets its flag
  a_r9_sw_sets: assert property (@(posedge clk) disable iff (!por_rst_n)
    set_sw |=> flags_q.sw);
  // R10: the pin sets the external flag
  a_r10_ext_sets: assert property (@(posedge clk) disable iff (!por_rst_n)
    ext_low |=> flags_q.ext);
  // R8: an expiry sets the watchdog flag
  a_r8_wdt_sets: assert property (@(posedge clk) disable iff (!por_rst_n)
    set_wdt |=> flags_q.wdt);
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
  import wdg_pkg::*;
#(
  parameter int unsigned MAIN_LOG [NCODES] = '{12, 14, 16, 19},
  parameter int unsigned SUB_LOG  [NCODES] = '{10, 13, 14, 15}
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       rst_n,
  input  logic       ext_pin_n,
  input  logic       src_sel,
  input  logic       sub_tick,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic       bus_addr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       wdt_rst_req,
  output logic       sw_rst_req
);
  localparam int unsigned MAIN_W = max4(MAIN_LOG[0], MAIN_LOG[1], MAIN_LOG[2], MAIN_LOG[3]);
  localparam int unsigned SUB_W  = max4(SUB_LOG[0], SUB_LOG[1], SUB_LOG[2], SUB_LOG[3]);

  logic              sys_arst_n, sys_rst_n, por_rst_n;
  logic [MAIN_W-1:0] main_cnt;
  logic [SUB_W-1:0]  sub_cnt;
  logic              acc_ctl, acc_swr;
  logic              kick, rd_clr, sw_hit;
  logic              sw_req_q, sw_req_d;
  logic              expire;
  cause_t            flags;
  logic              unused_wdata;

  assign sys_arst_n = rst_n & por_n;

  wdg_reset_sync u_sys_sync (.clk(clk), .arst_n(sys_arst_n), .srst_n(sys_rst_n));
  wdg_reset_sync u_por_sync (.clk(clk), .arst_n(por_n),      .srst_n(por_rst_n));

  // Register decode
  assign acc_ctl = bus_sel && !bus_addr;
  assign acc_swr = bus_sel &&  bus_addr;
  assign kick    = acc_ctl && bus_wr && !bus_wdata[POS_CTL];
  assign rd_clr  = acc_ctl && !bus_wr;
  assign sw_hit  = acc_swr && bus_wr && bus_wdata[0];
  assign unused_wdata = ^bus_wdata[7:3];

  always_comb begin
    bus_rdata = 8'h00;
    if (!bus_addr) begin
      bus_rdata[POS_POR]  = flags.por;
      bus_rdata[POS_WDT]  = flags.wdt;
      bus_rdata[POS_EXT]  = flags.ext;
      bus_rdata[POS_SW]   = flags.sw;
      bus_rdata[2:0]      = 3'b111;
    end
  end

  wdg_prescaler #(.WIDTH(MAIN_W)) u_main_ps (
    .clk(clk), .rst_n(sys_rst_n), .adv(1'b1), .count(main_cnt));

  wdg_prescaler #(.WIDTH(SUB_W)) u_sub_ps (
    .clk(clk), .rst_n(sys_rst_n), .adv(sub_tick), .count(sub_cnt));

  wdg_expiry #(
    .MAIN_LOG(MAIN_LOG), .SUB_LOG(SUB_LOG), .MAIN_W(MAIN_W), .SUB_W(SUB_W)
  ) u_expiry (
    .clk(clk), .rst_n(sys_rst_n), .kick(kick), .code_in(bus_wdata[1:0]),
    .src_sel(src_sel), .main_cnt(main_cnt), .sub_cnt(sub_cnt), .expire(expire));

  wdg_cause_flags u_flags (
    .clk(clk), .por_rst_n(por_rst_n), .set_wdt(expire), .set_sw(sw_hit),
    .ext_pin_n(ext_pin_n), .rd_clr(rd_clr), .flags(flags));

  always_comb begin
    sw_req_d = sw_hit;
  end

  always_ff @(posedge clk or negedge sys_rst_n) begin
    if (!sys_rst_n) sw_req_q <= 1'b0;
    else            sw_req_q <= sw_req_d;
  end

  assign sw_rst_req  = sw_req_q;
  assign wdt_rst_req = expire;

  // R9: a software request pulse is backed by its flag
  a_r9_sw_flag: assert property (@(posedge clk) disable iff (!sys_rst_n || !por_rst_n)
    sw_req_q |-> flags.sw);
  // R1: the low three bits of the cause register always read 1
  a_r1_low_ones: assert property (@(posedge clk) disable iff (!sys_rst_n)
    !bus_addr |-> (bus_rdata[2:0] == 3'b111));
endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
  logic       clk = 1'b0;
  logic       por_n, rst_n, ext_pin_n, src_sel, sub_tick;
  logic       bus_sel, bus_wr, bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  logic       wdt_rst_req, sw_rst_req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  localparam int P_SUB = 4;
  localparam int unsigned M_LOG [4] = '{4, 5, 6, 7};
  localparam int unsigned S_LOG [4] = '{3, 4, 5, 6};

  always #10 clk = ~clk;

  wdog_guard #(.MAIN_LOG(M_LOG), .SUB_LOG(S_LOG)) u_dut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .ext_pin_n(ext_pin_n),
    .src_sel(src_sel), .sub_tick(sub_tick), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .wdt_rst_req(wdt_rst_req), .sw_rst_req(sw_rst_req));

  // sub-clock strobe generator
  int tick_div = 0;
  always @(negedge clk) begin
    tick_div <= (tick_div == P_SUB-1) ? 0 : tick_div + 1;
    sub_tick <= (tick_div == P_SUB-1);
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic bus_write(input bit addr, input logic [7:0] data, output bit saw_sw);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = addr; bus_wdata = data;
    @(negedge clk);
    saw_sw = sw_rst_req;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input bit addr, output logic [7:0] data);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = addr;
    #1 data = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic sys_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic power_on();
    @(negedge clk);
    por_n = 1'b0; rst_n = 1'b0;
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // Counts negedges from the current one until wdt_rst_req is seen; -1 if not within limit.
  task automatic wait_req(input int limit, output int n);
    n = -1;
    for (int i = 0; i <= limit; i++) begin
      if (wdt_rst_req) begin n = i; break; end
      @(negedge clk);
    end
  endtask

  task automatic quiet(input int cycles, input string req);
    int hits = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (wdt_rst_req) hits++;
    end
    chk(hits == 0, req, hits, 0);
  endtask

  task automatic t_power_on();
    logic [7:0] d;
    power_on();
    bus_read(1'b0, d);
    chk(d == 8'h87, "R1 power-on readback", d, 8'h87);
    bus_read(1'b0, d);
    chk(d == 8'h07, "R2 read clears flags", d, 8'h07);
  endtask

  task automatic t_idle();
    bit s; int n;
    quiet(600, "R3 no request before arming");
    bus_write(1'b0, 8'h04, s);
    quiet(600, "R3 writing control bit 1 does not arm");
    bus_write(1'b0, 8'h00, s);
    wait_req(4*16+10, n);
    chk(n >= 3*16 && n <= 4*16+2, "R3 write of 0 arms", n, 3*16);
  endtask

  task automatic t_main_codes();
    bit s; int n; int t; logic [7:0] d;
    src_sel = 1'b0;
    for (int k = 0; k < 4; k++) begin
      sys_reset();
      t = 1 << M_LOG[k];
      bus_write(1'b0, 8'(k), s);
      wait_req(4*t+10, n);
      chk(n >= 3*t && n <= 4*t+2, $sformatf("R4 main timeout code %0d", k), n, 3*t);
      @(negedge clk);
      chk(wdt_rst_req == 1'b0, "R8 request lasts one cycle", wdt_rst_req, 0);
      if (k == 0) sys_reset();
      bus_read(1'b0, d);
      chk(d == 8'h27, $sformatf("R8 watchdog flag set, R11 held across reset (code %0d)", k), d, 8'h27);
    end
  endtask

  task automatic t_service();
    bit s; int n; int hits = 0;
    sys_reset();
    bus_write(1'b0, 8'h00, s);
    for (int i = 0; i < 10; i++) begin
      for (int j = 0; j < 28; j++) begin
        @(negedge clk);
        if (wdt_rst_req) hits++;
      end
      bus_write(1'b0, 8'h00, s);
    end
    chk(hits == 0, "R5 service keeps request low", hits, 0);
    wait_req(4*16+10, n);
    chk(n >= 3*16 && n <= 4*16+2, "R5 expiry after last service", n, 3*16);
  endtask

  task automatic t_latch();
    bit s; int n;
    sys_reset();
    bus_write(1'b0, 8'h00, s);
    bus_write(1'b0, 8'h03, s);
    wait_req(4*16+10, n);
    chk(n >= 3*16 && n <= 4*16+2, "R6 code latched at arming", n, 3*16);
  endtask

  task automatic t_sub();
    bit s; int n; int t;
    sys_reset();
    src_sel = 1'b1;
    t = (1 << S_LOG[1]) * P_SUB;
    bus_write(1'b0, 8'h01, s);
    wait_req(4*t+3*P_SUB, n);
    chk(n >= 3*t-P_SUB && n <= 4*t+2*P_SUB, "R7 sub-clock timeout", n, 3*t);
    src_sel = 1'b0;
  endtask

  task automatic t_software();
    bit s; logic [7:0] d;
    sys_reset();
    bus_read(1'b0, d);
    bus_write(1'b1, 8'h01, s);
    chk(s == 1'b1, "R9 software request pulse", s, 1);
    @(negedge clk);
    chk(sw_rst_req == 1'b0, "R9 software pulse one cycle", sw_rst_req, 0);
    bus_write(1'b1, 8'h00, s);
    chk(s == 1'b0, "R9 write of 0 gives no pulse", s, 0);
    bus_read(1'b0, d);
    chk(d == 8'h0F, "R9 software flag set", d, 8'h0F);
  endtask

  task automatic t_external();
    bit s; logic [7:0] d;
    bus_write(1'b1, 8'h01, s);
    @(negedge clk);
    ext_pin_n = 1'b0; rst_n = 1'b0;
    repeat (6) @(negedge clk);
    ext_pin_n = 1'b1; rst_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_read(1'b0, d);
    chk(d == 8'h1F, "R10 external flag set, software flag held", d, 8'h1F);
    quiet(600, "R11 reset disarms watchdog");
    power_on();
    bus_read(1'b0, d);
    chk(d == 8'h87, "R1 power-on clears other flags", d, 8'h87);
  endtask

  initial begin
    por_n = 1'b0; rst_n = 1'b0; ext_pin_n = 1'b1; src_sel = 1'b0; sub_tick = 1'b0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = 1'b0; bus_wdata = 8'h00;
    t_power_on();
    t_idle();
    t_main_codes();
    t_service();
    t_latch();
    t_sub();
    t_software();
    t_external();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule